// File: doc/BRIEF.md
# Multifunction Interrupt Pin Router

This block sits beside a two-socket card controller and decides what appears on each of seven general-purpose output terminals. Each socket has four event inputs. An event sets a sticky flag for that socket. Each socket has its own mask and its own legacy IRQ number. A socket is *pending* while any of its flags is set with the matching mask bit also set.

One shared routing register holds a 4-bit selector for each terminal. A selector can place a PCI interrupt line on the terminal, place one numbered legacy IRQ (3 to 15) on it, or leave the terminal idle. Terminal 0 is the only place where INTA can appear, and terminal 1 is the only place where INTB can appear. A tie bit folds socket B onto INTA and changes the interrupt-pin identifier that the second function reports.

Software reaches the block through a simple register port on behalf of either of two functions. Function 0 owns socket A and function 1 owns socket B. Every terminal output is an active-high level.

A mode bit selects how flags are cleared. In the default mode, reading the flags clears them. In the other mode, a flag clears only when a 1 is written to it.

Top module: `mfunc_irq_router`

## Requirements
- R1: Register address 0 is the routing register, and it is shared. A write from either function (`reg_func`) updates the single copy, and a read from either function returns it. Bits 31:28 always read as zero. Terminal i uses bits 4i+3:4i.
- R2: Selector 0 or 1 drives the terminal low. Selector 2 places INTA on terminal 0 and INTB on terminal 1. On terminals 2 to 6, selector 2 drives the terminal low.
- R3: A selector n in the range 3 to 15 drives the terminal high while at least one pending socket has n as its IRQ number. The IRQ number is held in bits 11:8 of that socket's config register at address 3. IRQ numbers below 3 route nowhere.
- R4: INTA is high when socket A is pending, or when the tie bit is set and socket B is pending. INTB is high when socket B is pending and the tie bit is clear. INTB is low whenever the tie bit is set.
- R5: Address 4 is a read-only interrupt-pin identifier. Function 0 reads 01h. Function 1 reads 02h, or 01h while the tie bit is set.
- R6: An event input bit sets the flag of the same index in that socket's flag register (address 2, bits 3:0). A flag only makes the socket pending if its mask bit is also set (address 3, bits 3:0).
- R7: Control register (address 1): bit 0 is the tie bit and bit 1 is the clear mode. When bit 1 is 0, a read of address 2 returns the flags and then clears them, and writes to address 2 have no effect.
- R8: When control bit 1 is 1, writing a 1 to a flag bit clears that flag, writing a 0 keeps it, and reads do not clear anything.
- R9: When an event sets a flag in the same cycle as a clear of that flag, the flag ends up set.
- R10: Reset, which is synchronous and active high, clears the routing register, the control bits, all flags, the masks and the IRQ numbers. All terminals are then driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for clear-on-read) |
| reg_func | input | 1 | Requesting function: 0 selects socket A, 1 selects socket B |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address and function |
| sock_a_evt | input | 4 | Socket A event inputs |
| sock_b_evt | input | 4 | Socket B event inputs |
| mfunc_out | output | 7 | Terminal level outputs, terminal 0 in bit 0 |

## Verification
The routing function is driven from a vector table. The table combines routing words, tie settings, socket event patterns and socket IRQ numbers, and each row is compared with a terminal vector worked out by hand.

The rows are chosen so that each one separates a particular pair of cases:
- Which socket drives a shared IRQ number.
- INTA versus INTB when the tie bit is on and when it is off.
- Selector 2 on terminals that may carry INTx versus terminals that may not.
- Idle selectors.
- The same IRQ placed on every terminal, including terminal 0.

Directed tests then cover:
- Both flag-clearing modes.
- Masking.
- A set and a clear landing in the same cycle.
- Shared register access from either function.
- Reset in the middle of a run.

// File: rtl/mfunc_irq_pkg.sv
package mfunc_irq_pkg;

    localparam int NUM_TERM  = 7;
    localparam int NUM_SOCK  = 2;
    localparam int SEL_W     = 4;
    localparam int EVT_W     = 4;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 32;
    localparam int ROUTE_W   = NUM_TERM * SEL_W;
    localparam int IRQ_LINES = 1 << SEL_W;

    localparam logic [SEL_W-1:0] SEL_INTX    = 4'd2;
    localparam logic [SEL_W-1:0] SEL_IRQ_MIN = 4'd3;

    // Field position of the IRQ number inside the socket config word.
    localparam int CFG_IRQ_LSB = 8;

    typedef enum logic [ADDR_W-1:0] {
        RA_ROUTE   = 3'd0,
        RA_CTRL    = 3'd1,
        RA_FLAGS   = 3'd2,
        RA_SOCKCFG = 3'd3,
        RA_PINID   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic w1c_mode;
        logic tie;
    } ctrl_t;

    typedef struct packed {
        logic [SEL_W-1:0] irq;
        logic [EVT_W-1:0] mask;
    } sock_cfg_t;

    function automatic logic [7:0] pin_code(input logic func, input logic tie);
        return (func && !tie) ? 8'h02 : 8'h01;
    endfunction

    function automatic logic irq_valid(input logic [SEL_W-1:0] n);
        return n >= SEL_IRQ_MIN;
    endfunction

endpackage

// File: rtl/mfunc_route_regs.sv
module mfunc_route_regs
    import mfunc_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_route,
    input  logic               wr_ctrl,
    input  logic [DATA_W-1:0]  wdata,
    output logic [ROUTE_W-1:0] route_q,
    output ctrl_t              ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= '0;
            ctrl_q  <= '0;
        end else begin
            if (wr_route) route_q <= wdata[ROUTE_W-1:0];
            if (wr_ctrl) begin
                ctrl_q.tie      <= wdata[0];
                ctrl_q.w1c_mode <= wdata[1];
            end
        end
    end

    AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_route |=> $stable(route_q)); // R1

endmodule

// File: rtl/mfunc_sock_flags.sv
module mfunc_sock_flags
    import mfunc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] evt,
    input  logic             w1c_mode,
    input  logic             wr_flags,
    input  logic             rd_flags,
    input  logic             wr_cfg,
    input  logic [EVT_W-1:0] wr_bits,
    input  logic [SEL_W-1:0] wr_irq,
    output logic [EVT_W-1:0] flags_q,
    output sock_cfg_t        cfg_q,
    output logic             pending
);

    logic [EVT_W-1:0] clr_bits;

    always_comb begin
        clr_bits = '0;
        if (w1c_mode) begin
            if (wr_flags) clr_bits = wr_bits;
        end else begin
            if (rd_flags) clr_bits = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            cfg_q   <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_bits) | evt;
            if (wr_cfg) begin
                cfg_q.mask <= wr_bits;
                cfg_q.irq  <= wr_irq;
            end
        end
    end

    assign pending = |(flags_q & cfg_q.mask);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((flags_q & $past(evt)) == $past(evt))); // R9

    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_flags && !w1c_mode && evt == '0) |=> (flags_q == '0)); // R7

    AST_W1C_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (w1c_mode && !wr_flags) |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R8

endmodule

// File: rtl/mfunc_term_mux.sv
module mfunc_term_mux
    import mfunc_irq_pkg::*;
#(
    parameter bit INTX_ALLOWED = 1'b0
) (
    input  logic [SEL_W-1:0]     sel,
    input  logic                 intx,
    input  logic [IRQ_LINES-1:0] irq_vec,
    output logic                 term_out
);

    always_comb begin
        if (sel == SEL_INTX)
            term_out = INTX_ALLOWED ? intx : 1'b0;
        else if (irq_valid(sel))
            term_out = irq_vec[sel];
        else
            term_out = 1'b0;
    end

endmodule

// File: rtl/mfunc_irq_router.sv
module mfunc_irq_router
    import mfunc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_func,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [3:0]        sock_a_evt,
    input  logic [3:0]        sock_b_evt,
    output logic [6:0]        mfunc_out
);

    logic [ROUTE_W-1:0]   route_q;
    ctrl_t                ctrl_q;
    logic [EVT_W-1:0]     evt     [NUM_SOCK];
    logic [EVT_W-1:0]     flags   [NUM_SOCK];
    sock_cfg_t            cfg     [NUM_SOCK];
    logic [NUM_SOCK-1:0]  pending;
    logic [IRQ_LINES-1:0] irq_vec;
    logic                 inta, intb;
    logic [NUM_TERM-1:0]  intx_line;
    reg_addr_e            addr;

    assign addr   = reg_addr_e'(reg_addr);
    assign evt[0] = sock_a_evt;
    assign evt[1] = sock_b_evt;

    mfunc_route_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_route (reg_wr && addr == RA_ROUTE),
        .wr_ctrl  (reg_wr && addr == RA_CTRL),
        .wdata    (reg_wdata),
        .route_q  (route_q),
        .ctrl_q   (ctrl_q)
    );

    for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
        logic mine;
        assign mine = (reg_func == 1'(s));
        mfunc_sock_flags u_flags (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt[s]),
            .w1c_mode (ctrl_q.w1c_mode),
            .wr_flags (reg_wr && mine && addr == RA_FLAGS),
            .rd_flags (reg_rd && mine && addr == RA_FLAGS),
            .wr_cfg   (reg_wr && mine && addr == RA_SOCKCFG),
            .wr_bits  (reg_wdata[EVT_W-1:0]),
            .wr_irq   (reg_wdata[CFG_IRQ_LSB +: SEL_W]),
            .flags_q  (flags[s]),
            .cfg_q    (cfg[s]),
            .pending  (pending[s])
        );
    end

    // Legacy IRQ lines: each socket drives the line its IRQ number names.
    always_comb begin
        irq_vec = '0;
        for (int s = 0; s < NUM_SOCK; s++)
            if (pending[s] && irq_valid(cfg[s].irq))
                irq_vec[cfg[s].irq] = 1'b1;
    end

    assign inta = pending[0] | (ctrl_q.tie & pending[1]);
    assign intb = pending[1] & ~ctrl_q.tie;

    for (genvar t = 0; t < NUM_TERM; t++) begin : g_term
        if (t == 0) begin : g_a
            assign intx_line[t] = inta;
        end else if (t == 1) begin : g_b
            assign intx_line[t] = intb;
        end else begin : g_none
            assign intx_line[t] = 1'b0;
        end
        mfunc_term_mux #(.INTX_ALLOWED(t < 2)) u_mux (
            .sel      (route_q[t*SEL_W +: SEL_W]),
            .intx     (intx_line[t]),
            .irq_vec  (irq_vec),
            .term_out (mfunc_out[t])
        );
    end

    always_comb begin
        reg_rdata = '0;
        case (addr)
            RA_ROUTE:   reg_rdata[ROUTE_W-1:0] = route_q;
            RA_CTRL:    reg_rdata[1:0] = {ctrl_q.w1c_mode, ctrl_q.tie};
            RA_FLAGS:   reg_rdata[EVT_W-1:0] = flags[reg_func];
            RA_SOCKCFG: begin
                reg_rdata[EVT_W-1:0] = cfg[reg_func].mask;
                reg_rdata[CFG_IRQ_LSB +: SEL_W] = cfg[reg_func].irq;
            end
            RA_PINID:   reg_rdata[7:0] = pin_code(reg_func, ctrl_q.tie);
            default:    reg_rdata = '0;
        endcase
    end

    AST_TIE_MUTES_INTB: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.tie && route_q[SEL_W +: SEL_W] == SEL_INTX) |-> !mfunc_out[1]); // R4

    AST_INTX_PLACEMENT: assert property (@(posedge clk) disable iff (rst)
        (route_q[2*SEL_W +: SEL_W] == SEL_INTX) |-> !mfunc_out[2]); // R2

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr == RA_ROUTE) |-> (reg_rdata[31:28] == 4'h0)); // R1

    AST_PIN_ID: assert property (@(posedge clk) disable iff (rst)
        (addr == RA_PINID && !reg_func) |-> (reg_rdata == 32'h1)); // R5

endmodule

// File: tb/mfunc_irq_router_bench.sv
module mfunc_irq_router_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] route;
        logic        tie;
        logic [3:0]  ea;
        logic [3:0]  eb;
        logic [3:0]  ia;
        logic [3:0]  ib;
        logic [6:0]  expect_out;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0FBA5432, 1'b0, 4'h1, 4'h0, 4'd3,  4'd4,  7'b0000011},
        '{32'h0FBA5432, 1'b0, 4'h0, 4'h2, 4'd3,  4'd10, 7'b0010000},
        '{32'h0FBA5432, 1'b1, 4'h0, 4'h1, 4'd5,  4'd15, 7'b1000001},
        '{32'h00000022, 1'b0, 4'h0, 4'h1, 4'd0,  4'd0,  7'b0000010},
        '{32'h00000022, 1'b1, 4'h0, 4'h1, 4'd0,  4'd0,  7'b0000001},
        '{32'h02222222, 1'b0, 4'h8, 4'h4, 4'd0,  4'd0,  7'b0000011},
        '{32'h01111110, 1'b0, 4'hF, 4'hF, 4'd1,  4'd1,  7'b0000000},
        '{32'h03333333, 1'b0, 4'h2, 4'h0, 4'd3,  4'd9,  7'b1111111}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_func = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  sock_a_evt = '0, sock_b_evt = '0;
    logic [6:0]  mfunc_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mfunc_irq_router u_mfunc_irq_router (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_func(reg_func), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sock_a_evt(sock_a_evt),
        .sock_b_evt(sock_b_evt), .mfunc_out(mfunc_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic f, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_func = f; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic f, input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_func = f; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] ea, input logic [3:0] eb);
        @(negedge clk);
        sock_a_evt = ea; sock_b_evt = eb;
        @(negedge clk);
        sock_a_evt = '0; sock_b_evt = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (2) @(negedge clk);

        // Routing table: R2, R3, R4 under several patterns.
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            wr(1'b0, 3'd0, VECS[i].route);
            wr(1'b0, 3'd1, {31'd0, VECS[i].tie});
            wr(1'b0, 3'd3, {20'd0, VECS[i].ia, 4'd0, 4'hF});
            wr(1'b1, 3'd3, {20'd0, VECS[i].ib, 4'd0, 4'hF});
            pulse(VECS[i].ea, VECS[i].eb);
            check($sformatf("R2/R3/R4 vector %0d", i), {25'd0, mfunc_out}, {25'd0, VECS[i].expect_out});
        end

        // R10 and R5: reset state.
        do_reset();
        check("R10 outputs after reset", {25'd0, mfunc_out}, 32'h0);
        rd(1'b1, 3'd0, d); check("R10 route after reset", d, 32'h0);
        rd(1'b0, 3'd1, d); check("R10 ctrl after reset", d, 32'h0);
        rd(1'b0, 3'd2, d); check("R10 flags after reset", d, 32'h0);
        rd(1'b0, 3'd4, d); check("R5 pin func0", d, 32'h01);
        rd(1'b1, 3'd4, d); check("R5 pin func1 untied", d, 32'h02);

        // R1: shared routing register, reserved nibble.
        wr(1'b1, 3'd0, 32'hFFFFFFFF);
        rd(1'b0, 3'd0, d); check("R1 read via func0", d, 32'h0FFFFFFF);
        rd(1'b1, 3'd0, d); check("R1 read via func1", d, 32'h0FFFFFFF);

        // R5 with tie.
        wr(1'b0, 3'd1, 32'h1);
        rd(1'b1, 3'd4, d); check("R5 pin func1 tied", d, 32'h01);

        // R6 masking, R7 clear-on-read.
        do_reset();
        wr(1'b0, 3'd0, 32'h00000002);
        pulse(4'h5, 4'h0);
        check("R6 masked flag not routed", {31'd0, mfunc_out[0]}, 32'h0);
        rd(1'b0, 3'd2, d); check("R7 read returns flags", d, 32'h5);
        rd(1'b0, 3'd2, d); check("R7 read cleared flags", d, 32'h0);
        pulse(4'h3, 4'h0);
        wr(1'b0, 3'd2, 32'hF);
        rd(1'b0, 3'd2, d); check("R7 write ignored in read-clear mode", d, 32'h3);
        wr(1'b0, 3'd3, 32'h0000000F);
        pulse(4'h1, 4'h0);
        check("R6 unmasked flag drives INTA", {31'd0, mfunc_out[0]}, 32'h1);
        rd(1'b0, 3'd2, d); check("R7 flag read", d, 32'h1);
        check("R7 output drops after read", {31'd0, mfunc_out[0]}, 32'h0);

        // R8: write-one-to-clear.
        wr(1'b0, 3'd1, 32'h2);
        pulse(4'h6, 4'h0);
        wr(1'b0, 3'd2, 32'h2);
        rd(1'b0, 3'd2, d); check("R8 write 1 clears bit", d, 32'h4);
        rd(1'b0, 3'd2, d); check("R8 read does not clear", d, 32'h4);
        wr(1'b0, 3'd2, 32'h0);
        rd(1'b0, 3'd2, d); check("R8 write 0 keeps", d, 32'h4);
        check("R8 still pending on INTA", {31'd0, mfunc_out[0]}, 32'h1);

        // R9: set wins over a same-cycle write clear.
        @(negedge clk);
        reg_wr = 1'b1; reg_func = 1'b0; reg_addr = 3'd2; reg_wdata = 32'h4; sock_a_evt = 4'h4;
        @(negedge clk);
        reg_wr = 1'b0; sock_a_evt = '0;
        rd(1'b0, 3'd2, d); check("R9 set beats write clear", d, 32'h4);

        // R9: set wins over a same-cycle read clear.
        wr(1'b0, 3'd1, 32'h0);
        @(negedge clk);
        reg_rd = 1'b1; reg_func = 1'b0; reg_addr = 3'd2; sock_a_evt = 4'h1;
        @(negedge clk);
        reg_rd = 1'b0; sock_a_evt = '0;
        rd(1'b0, 3'd2, d); check("R9 set beats read clear", d, 32'h1);

        // R10: reset mid-run.
        wr(1'b0, 3'd0, 32'h00000002);
        wr(1'b0, 3'd1, 32'h3);
        pulse(4'hF, 4'hF);
        do_reset();
        check("R10 outputs after mid-run reset", {25'd0, mfunc_out}, 32'h0);
        rd(1'b0, 3'd0, d); check("R10 route cleared", d, 32'h0);
        rd(1'b0, 3'd1, d); check("R10 ctrl cleared", d, 32'h0);
        rd(1'b1, 3'd3, d); check("R10 socket config cleared", d, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule